// File: doc/BRIEF.md
# Serial Command Packet Controller

This block sits behind a byte-level UART receiver. It turns the incoming stream of bytes into commands for the threshold, masking, rate-count, test-pulse and monitor-select functions of a trigger front-end board. The receiver delivers each byte together with a one-cycle valid pulse. The first byte of every packet is a control word. Its upper six bits name the command, and its lower two bits carry an argument that two of the commands use. Some commands also take data bytes. The number of data bytes is fixed for each command, and the block collects them one by one.

A one-hot sequencer tracks where the block is inside a packet. The block raises a one-cycle strobe when a command is recognized and a store strobe for every data byte. When a packet is complete it presents the assembled words, such as the 24-bit mask and the 16-bit converter word. A gap timer drops a partial packet if the sender stalls, so a lost byte cannot shift the meaning of later bytes. Read commands raise a request strobe for a response path further downstream.

Top module: `cmd_pkt_ctrl`

## Requirements
- R1: After reset every strobe output is 0, every held word is 0, and the first byte received is treated as a control word.
- R2: The command code is control-word bits [7:2]. Codes 1 to 7 raise a one-cycle pulse on `cmd_pulse` bit code-1 in the cycle after the byte is accepted. The mapping is 1 mask write, 2 mask read, 3 converter write, 4 count read, 5 window select, 6 test fire, 7 monitor channel select.
- R3: Mask write takes 3 data bytes, converter write takes 2, and count read and channel select take 1 each. The other commands take none. Each data byte gives a one-cycle `store_stb` with a 0-based `store_idx` and the byte on `store_byte`. The byte after the last data byte is treated as a control word.
- R4: On the third mask data byte, `mask_load` pulses together with that byte's store strobe, and `mask_word` becomes {third, second, first}, so the first byte lands in bits [7:0]. `mask_word` holds its value otherwise.
- R5: On the second converter data byte, `dac_load` pulses and `dac_word` becomes {second, first}.
- R6: `resp_req` pulses together with the command pulse of a mask read. It also pulses together with the data-byte store of a count read, which loads `cnt_addr` with that byte.
- R7: The data byte of a channel select loads `chan_sel`, which then holds until the next channel select.
- R8: A window select loads `twin_sel` with control-word bits [1:0], which then hold until the next window select.
- R9: A test fire raises a one-cycle pulse on `test_fire` bit n, where n is control-word bits [1:0]. The other three bits stay 0.
- R10: A control word with code 0 or code 8 to 63 raises no output, and the next byte is again treated as a control word.
- R11: Let G = CLK_KHZ*TIMEOUT_MS. A data byte accepted up to G cycles after the previous byte of its packet is taken as data. If G cycles pass with no byte, the partial packet is dropped without any load, and the next byte is treated as a control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle qualifier for rx_data |
| cmd_pulse | output | 7 | One-hot command recognized strobe |
| store_stb | output | 1 | Data byte stored strobe |
| store_idx | output | 2 | Position of the stored byte inside its packet |
| store_byte | output | 8 | Last stored data byte |
| mask_word | output | 24 | Assembled channel mask |
| mask_load | output | 1 | Mask word updated strobe |
| dac_word | output | 16 | Assembled converter word {address byte, code byte} |
| dac_load | output | 1 | Converter word updated strobe |
| cnt_addr | output | 8 | Channel whose count is requested |
| chan_sel | output | 8 | Channel routed to the monitor output |
| twin_sel | output | 2 | Count window width select |
| test_fire | output | 4 | One-hot test pulse strobe |
| resp_req | output | 1 | Response request for read commands |

## Verification
The bench builds the block with CLK_KHZ=4 and TIMEOUT_MS=2, which gives a gap limit of 8 cycles. At that size every one of the 256 control-word values can be driven, together with its full data phase, back to back. The short limit also puts both sides of the timeout edge within reach in a few cycles: a byte arriving exactly G cycles after its predecessor, and one arriving a cycle later. A reset in the middle of a packet is covered too.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int BW    = 8;
  localparam int NCMD  = 7;
  localparam int NTP   = 4;
  localparam int NST   = 8;
  localparam int MSK_W = 3 * BW;
  localparam int DAC_W = 2 * BW;

  localparam int S_IDLE = 0;
  localparam int S_WM1  = 1;
  localparam int S_WM2  = 2;
  localparam int S_WM3  = 3;
  localparam int S_WD1  = 4;
  localparam int S_WD2  = 5;
  localparam int S_RC1  = 6;
  localparam int S_RH1  = 7;

  typedef enum logic [2:0] {
    C_WMASK  = 3'd0,
    C_RMASK  = 3'd1,
    C_WDAC   = 3'd2,
    C_RCNT   = 3'd3,
    C_TWIN   = 3'd4,
    C_TPULSE = 3'd5,
    C_RCHAN  = 3'd6
  } cmd_e;

  typedef struct packed {
    logic       ok;
    cmd_e       cmd;
    logic [1:0] arg;
  } cw_t;

  function automatic cw_t cw_decode(input logic [BW-1:0] cw);
    cw_t r;
    logic [5:0] code;
    code  = cw[7:2];
    r.ok  = (code >= 6'd1) && (code <= 6'(NCMD));
    r.cmd = r.ok ? cmd_e'(code[2:0] - 3'd1) : C_WMASK;
    r.arg = cw[1:0];
    return r;
  endfunction

  function automatic logic [1:0] cmd_len(input cmd_e c);
    case (c)
      C_WMASK: return 2'd3;
      C_WDAC:  return 2'd2;
      C_RCNT:  return 2'd1;
      C_RCHAN: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [NST-1:0] st_oh(input int i);
    return NST'(1) << i;
  endfunction
endpackage

// File: rtl/cpc_cw_decode.sv
module cpc_cw_decode
  import cpc_pkg::*;
(
  input  logic [BW-1:0] rx_data,
  output cw_t           dec
);
  always_comb dec = cw_decode(rx_data);
endmodule

// File: rtl/cpc_gap_timer.sv
module cpc_gap_timer #(
  parameter int GAP_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic kick,
  input  logic rx_valid,
  output logic gap_expired
);
  localparam int CNT_W = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (kick || !busy)  cnt <= '0;
    else if (cnt != LAST)    cnt <= cnt + 1'b1;
  end

  assign gap_expired = busy && !rx_valid && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R11
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !gap_expired); // R11
endmodule

// File: rtl/cpc_seq_fsm.sv
module cpc_seq_fsm
  import cpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  cw_t        dec,
  input  logic       gap_expired,
  output logic       busy,
  output logic       cw_take,
  output logic       dat_take,
  output cmd_e       dat_cmd,
  output logic [1:0] dat_idx,
  output logic       dat_last
);
  logic [NST-1:0] st, nx;

  assign busy     = !st[S_IDLE];
  assign cw_take  = st[S_IDLE] && rx_valid && dec.ok;
  assign dat_take = busy && rx_valid;

  always_comb begin
    dat_cmd  = C_WMASK;
    dat_idx  = 2'd0;
    dat_last = 1'b0;
    if (st[S_WM2]) dat_idx = 2'd1;
    if (st[S_WM3]) begin dat_idx = 2'd2; dat_last = 1'b1; end
    if (st[S_WD1]) dat_cmd = C_WDAC;
    if (st[S_WD2]) begin dat_cmd = C_WDAC; dat_idx = 2'd1; dat_last = 1'b1; end
    if (st[S_RC1]) begin dat_cmd = C_RCNT; dat_last = 1'b1; end
    if (st[S_RH1]) begin dat_cmd = C_RCHAN; dat_last = 1'b1; end
  end

  always_comb begin
    nx = st;
    if (gap_expired) nx = st_oh(S_IDLE);
    else if (cw_take) begin
      case (dec.cmd)
        C_WMASK: nx = st_oh(S_WM1);
        C_WDAC:  nx = st_oh(S_WD1);
        C_RCNT:  nx = st_oh(S_RC1);
        C_RCHAN: nx = st_oh(S_RH1);
        default: nx = st;
      endcase
    end else if (dat_take) begin
      nx = dat_last ? st_oh(S_IDLE) : (st << 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= st_oh(S_IDLE);
    else        st <= nx;
  end

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st) == 1); // R3
  AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_take && dat_last) |=> st[S_IDLE]); // R3
  AST_GAP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gap_expired |=> st[S_IDLE]); // R11
  AST_BAD_CW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st[S_IDLE] && rx_valid && !dec.ok) |=> st[S_IDLE]); // R10
endmodule

// File: rtl/cpc_datapath.sv
module cpc_datapath
  import cpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rx_data,
  input  cw_t              dec,
  input  logic             cw_take,
  input  logic             dat_take,
  input  cmd_e             dat_cmd,
  input  logic [1:0]       dat_idx,
  input  logic             dat_last,
  output logic [NCMD-1:0]  cmd_pulse,
  output logic             store_stb,
  output logic [1:0]       store_idx,
  output logic [BW-1:0]    store_byte,
  output logic [MSK_W-1:0] mask_word,
  output logic             mask_load,
  output logic [DAC_W-1:0] dac_word,
  output logic             dac_load,
  output logic [BW-1:0]    cnt_addr,
  output logic [BW-1:0]    chan_sel,
  output logic [1:0]       twin_sel,
  output logic [NTP-1:0]   test_fire,
  output logic             resp_req
);
  logic [2*BW-1:0] mbuf;
  logic [BW-1:0]   dbuf;
  logic            take_m, take_d, take_c, take_h;

  assign take_m = dat_take && (dat_cmd == C_WMASK);
  assign take_d = dat_take && (dat_cmd == C_WDAC);
  assign take_c = dat_take && (dat_cmd == C_RCNT);
  assign take_h = dat_take && (dat_cmd == C_RCHAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_pulse <= '0;
      test_fire <= '0;
      store_stb <= 1'b0;
      store_idx <= '0;
      store_byte <= '0;
      resp_req  <= 1'b0;
      twin_sel  <= '0;
    end else begin
      cmd_pulse <= cw_take ? (NCMD'(1) << dec.cmd) : '0;
      test_fire <= (cw_take && dec.cmd == C_TPULSE) ? (NTP'(1) << dec.arg) : '0;
      store_stb <= dat_take;
      if (dat_take) begin
        store_idx  <= dat_idx;
        store_byte <= rx_data;
      end
      resp_req <= (cw_take && dec.cmd == C_RMASK) || take_c;
      if (cw_take && dec.cmd == C_TWIN) twin_sel <= dec.arg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mbuf      <= '0;
      mask_word <= '0;
      mask_load <= 1'b0;
    end else begin
      mask_load <= take_m && dat_last;
      if (take_m) begin
        if (dat_last)               mask_word <= {rx_data, mbuf};
        else if (dat_idx == 2'd0)   mbuf[BW-1:0] <= rx_data;
        else                        mbuf[2*BW-1:BW] <= rx_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbuf     <= '0;
      dac_word <= '0;
      dac_load <= 1'b0;
      cnt_addr <= '0;
      chan_sel <= '0;
    end else begin
      dac_load <= take_d && dat_last;
      if (take_d) begin
        if (dat_last) dac_word <= {rx_data, dbuf};
        else          dbuf <= rx_data;
      end
      if (take_c) cnt_addr <= rx_data;
      if (take_h) chan_sel <= rx_data;
    end
  end

  AST_CMD_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse)); // R2
  AST_CMD_XOR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_stb && (cmd_pulse != '0))); // R3
  AST_MASK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    mask_load |-> (store_stb && store_idx == 2'd2)); // R4
  AST_DAC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> (store_stb && store_idx == 2'd1)); // R5
  AST_TEST_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_fire != '0) |-> (cmd_pulse[C_TPULSE] && $onehot0(test_fire))); // R9
  AST_RESP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_req |-> (cmd_pulse[C_RMASK] || store_stb)); // R6
endmodule

// File: rtl/cmd_pkt_ctrl.sv
module cmd_pkt_ctrl
  import cpc_pkg::*;
#(
  parameter int CLK_KHZ    = 10000,
  parameter int TIMEOUT_MS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic [6:0]  cmd_pulse,
  output logic        store_stb,
  output logic [1:0]  store_idx,
  output logic [7:0]  store_byte,
  output logic [23:0] mask_word,
  output logic        mask_load,
  output logic [15:0] dac_word,
  output logic        dac_load,
  output logic [7:0]  cnt_addr,
  output logic [7:0]  chan_sel,
  output logic [1:0]  twin_sel,
  output logic [3:0]  test_fire,
  output logic        resp_req
);
  localparam int GAP_CYC = CLK_KHZ * TIMEOUT_MS;

  cw_t        dec;
  logic       busy, cw_take, dat_take, dat_last, gap_expired;
  cmd_e       dat_cmd;
  logic [1:0] dat_idx;

  cpc_cw_decode u_dec (
    .rx_data (rx_data),
    .dec     (dec)
  );

  cpc_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .kick        (dat_take),
    .rx_valid    (rx_valid),
    .gap_expired (gap_expired)
  );

  cpc_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .dec         (dec),
    .gap_expired (gap_expired),
    .busy        (busy),
    .cw_take     (cw_take),
    .dat_take    (dat_take),
    .dat_cmd     (dat_cmd),
    .dat_idx     (dat_idx),
    .dat_last    (dat_last)
  );

  cpc_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_data    (rx_data),
    .dec        (dec),
    .cw_take    (cw_take),
    .dat_take   (dat_take),
    .dat_cmd    (dat_cmd),
    .dat_idx    (dat_idx),
    .dat_last   (dat_last),
    .cmd_pulse  (cmd_pulse),
    .store_stb  (store_stb),
    .store_idx  (store_idx),
    .store_byte (store_byte),
    .mask_word  (mask_word),
    .mask_load  (mask_load),
    .dac_word   (dac_word),
    .dac_load   (dac_load),
    .cnt_addr   (cnt_addr),
    .chan_sel   (chan_sel),
    .twin_sel   (twin_sel),
    .test_fire  (test_fire),
    .resp_req   (resp_req)
  );

  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_valid) |=> (cmd_pulse == '0 && store_stb)); // R3
endmodule

// File: tb/cmd_pkt_ctrl_tb_top.sv
module cmd_pkt_ctrl_tb_top;
  localparam int KHZ = 4;
  localparam int MS  = 2;
  localparam int GAP = KHZ * MS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic [6:0]  cmd_pulse;
  logic        store_stb;
  logic [1:0]  store_idx;
  logic [7:0]  store_byte;
  logic [23:0] mask_word;
  logic        mask_load;
  logic [15:0] dac_word;
  logic        dac_load;
  logic [7:0]  cnt_addr, chan_sel;
  logic [1:0]  twin_sel;
  logic [3:0]  test_fire;
  logic        resp_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [23:0] e_mask = '0;
  logic [15:0] e_dac = '0;
  logic [7:0]  e_cnt = '0, e_chan = '0;
  logic [1:0]  e_twin = '0;

  always #5 clk = ~clk;

  cmd_pkt_ctrl #(.CLK_KHZ(KHZ), .TIMEOUT_MS(MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .cmd_pulse(cmd_pulse), .store_stb(store_stb), .store_idx(store_idx),
    .store_byte(store_byte), .mask_word(mask_word), .mask_load(mask_load),
    .dac_word(dac_word), .dac_load(dac_load), .cnt_addr(cnt_addr),
    .chan_sel(chan_sel), .twin_sel(twin_sel), .test_fire(test_fire),
    .resp_req(resp_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input int idle);
    repeat (idle) @(negedge clk);
    rx_data = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " cmd_pulse"}, 32'(cmd_pulse), 0);
    chk({tag, " store_stb"}, 32'(store_stb), 0);
    chk({tag, " test_fire"}, 32'(test_fire), 0);
    chk({tag, " loads"}, {30'd0, mask_load, dac_load}, 0);
    chk({tag, " resp_req"}, 32'(resp_req), 0);
  endtask

  task automatic chk_held();
    chk("R4 mask_word held", 32'(mask_word), 32'(e_mask));
    chk("R5 dac_word held", 32'(dac_word), 32'(e_dac));
    chk("R6 cnt_addr held", 32'(cnt_addr), 32'(e_cnt));
    chk("R7 chan_sel held", 32'(chan_sel), 32'(e_chan));
    chk("R8 twin_sel held", 32'(twin_sel), 32'(e_twin));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_quiet("R1");
    chk_held();
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R10: sweep every control word with its data phase
    for (int cw = 0; cw < 256; cw++) begin
      int code;
      int len;
      logic [23:0] acc;
      code = cw >> 2;
      len  = (code == 1) ? 3 : (code == 3) ? 2 : (code == 4 || code == 7) ? 1 : 0;
      acc  = '0;
      send(8'(cw), 0);
      if (code >= 1 && code <= 7)
        chk("R2 cmd_pulse", 32'(cmd_pulse), 32'(1) << (code - 1));
      else
        chk("R10 cmd_pulse", 32'(cmd_pulse), 0);
      chk("R9 test_fire", 32'(test_fire), (code == 6) ? (32'(1) << (cw & 3)) : 0);
      if (code == 5) e_twin = 2'(cw & 3);
      chk("R8 twin_sel", 32'(twin_sel), 32'(e_twin));
      chk("R6 resp_req on mask read", 32'(resp_req), (code == 2) ? 1 : 0);
      chk("R3 no store on control word", 32'(store_stb), 0);
      for (int i = 0; i < len; i++) begin
        logic [7:0] d;
        d = 8'((cw * 7 + i * 61 + 13) & 255);
        send(d, (i % 2) ? 2 : 0);
        chk("R3 store_stb", 32'(store_stb), 1);
        chk("R3 store_idx", 32'(store_idx), 32'(i));
        chk("R3 store_byte", 32'(store_byte), 32'(d));
        acc[8*i +: 8] = d;
        if (code == 1 && i == 2) e_mask = acc;
        if (code == 3 && i == 1) e_dac = acc[15:0];
        if (code == 4) e_cnt = d;
        if (code == 7) e_chan = d;
        chk("R4 mask_load", 32'(mask_load), (code == 1 && i == 2) ? 1 : 0);
        chk("R5 dac_load", 32'(dac_load), (code == 3 && i == 1) ? 1 : 0);
        chk("R6 resp_req on count read", 32'(resp_req), (code == 4) ? 1 : 0);
        chk("R3 no cmd on data", 32'(cmd_pulse), 0);
        chk_held();
      end
      @(negedge clk);
      chk_quiet("R2 one-cycle");
      chk_held();
    end

    // R11: byte exactly G cycles after predecessor is data, G+1 is a new control word
    send(8'h04, 0);
    send(8'hA1, GAP - 1);
    chk("R11 in-window store", 32'(store_stb), 1);
    chk("R11 in-window idx", 32'(store_idx), 0);
    send(8'hB2, GAP - 1);
    chk("R11 in-window idx second", 32'(store_idx), 1);
    send(8'h10, GAP);
    chk("R11 late byte decoded", 32'(cmd_pulse), 32'h08);
    chk("R11 late byte not stored", 32'(store_stb), 0);
    chk("R11 no mask load", 32'(mask_word), 32'(e_mask));
    send(8'h44, 0);
    e_cnt = 8'h44;
    chk("R11 new packet data", 32'(cnt_addr), 32'(e_cnt));
    chk("R6 resp after timeout", 32'(resp_req), 1);

    // R11: converter packet abandoned after one byte
    send(8'h0C, 0);
    send(8'h5A, 0);
    send(8'h1A, GAP);
    chk("R11 dac abandoned", 32'(dac_word), 32'(e_dac));
    chk("R9 fire after abandon", 32'(test_fire), 32'h4);

    // R1: reset mid-packet returns to control-word state
    send(8'h04, 0);
    send(8'h77, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mask", 32'(mask_word), 0);
    chk("R1 reset chan", 32'(chan_sel), 0);
    rst_n = 1'b1;
    e_mask = '0; e_dac = '0; e_cnt = '0; e_chan = '0; e_twin = '0;
    send(8'h17, 0);
    chk("R1 first byte is control", 32'(cmd_pulse), 32'h10);
    e_twin = 2'd3;
    chk("R8 after reset", 32'(twin_sel), 32'(e_twin));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule